// File: doc/BRIEF.md
# CAN Controller Interrupt Flag and Event Capture Unit

This unit holds the interrupt state of a CAN controller as a CPU sees it on a simple register bus. The protocol engine feeds it event inputs. These are a receive-buffer-full level, a transmit-buffer-1 completion pulse, an error or bus status change, a data overrun, a wake-up, a bus error with an error-code snapshot, an arbitration loss with a bit position, and four auxiliary event pulses. The unit keeps one flag per source and an enable mask of the same width, and it drives a single registered interrupt request.

Each source clears in its own way. The receive flag follows the buffer level, and a read does not clear it. A release-buffer command clears it for one cycle, and it comes back if another message is waiting. The bus-error and arbitration-loss sources freeze their snapshots on the first event. Later events of that kind are ignored until software reads the status word once. The wake-up flag sets even when its source is masked. An attempt to sleep while the bus is active, or while an enabled interrupt is pending, also sets the wake-up flag.

Top module: `can_irq_unit`

## Requirements
- R1: After reset, the status word, the enable mask and the interrupt request are all zero.
- R2: `irq` is high in the cycle after some flag and its enable bit are both 1. A flag whose enable bit is 0 never raises `irq`.
- R3: The receive flag (status bit 0) is 1 one cycle after `rx_full` is 1, and a status read (`stat_rd`) does not clear it.
- R4: A `rx_release` pulse makes status bit 0 read 0 in the following cycle. In the cycle after that it reads 1 again if `rx_full` is still 1, and otherwise it stays 0.
- R5: The flags for transmit-buffer-1 done (bit 1), status change (bit 2), overrun (bit 3) and the auxiliary events (bits 7 to 10, `aux_evt[0]` at bit 7) each set one cycle after their event. A status read clears them. An event in the same cycle as the read leaves its flag set.
- R6: The wake-up flag (bit 4) sets on `wake_evt`. It also sets on `sleep_req` while `bus_active` is 1 or while any flag is set together with its enable bit. It sets even when its enable bit is 0, and then `irq` stays low.
- R7: On a bus error while bit 5 is clear, `berr_code` is stored in status bits 23:16 and bit 5 sets. While bit 5 is set, further bus errors change neither the stored code nor the flag. A status read clears bit 5 and re-arms the capture.
- R8: On an arbitration loss while bit 6 is clear, the 5-bit position `arb_pos` is stored in status bits 28:24, bits 31:29 read 0, and bit 6 sets. The position is 0 for the first identifier bit, 11 for the SRR/RTR bit, 12 for IDE, 13 to 30 for the extended identifier bits and 31 for the extended RTR bit. The field holds until a status read, and that read clears bit 6.
- R9: Status bits 15:11 always read 0, and the enable mask reads back on `en_rdata` exactly as it was last written through `en_wr`/`en_wdata`.
- R10: A bus error or arbitration loss that arrives in the same cycle as a status read is captured. The new value is stored and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_full | input | 1 | Receive buffer holds a message (level) |
| rx_release | input | 1 | Release-receive-buffer command pulse |
| tx1_done | input | 1 | Transmit buffer 1 sent or freed by abort |
| err_change | input | 1 | Error or bus status changed |
| overrun | input | 1 | Data overrun event |
| aux_evt | input | 4 | Auxiliary event pulses |
| wake_evt | input | 1 | Bus wake-up event |
| sleep_req | input | 1 | Software attempts to enter sleep |
| bus_active | input | 1 | Controller is busy on the bus |
| berr_evt | input | 1 | Bus error event |
| berr_code | input | 8 | Error code at the bus error |
| arb_lost_evt | input | 1 | Arbitration lost event |
| arb_pos | input | 5 | Bit position of the arbitration loss |
| en_wr | input | 1 | Write strobe for the enable mask |
| en_wdata | input | 11 | New enable mask |
| stat_rd | input | 1 | CPU read of the status word |
| en_rdata | output | 11 | Enable mask read-back |
| stat_word | output | 32 | Status word: flags, error code, arbitration position |
| irq | output | 1 | Interrupt request |

## Verification
Every flag, capture and enable register appears directly in `stat_word` or `en_rdata`, so a wrong internal state shows at the ports in the cycle after the edge that caused it. `irq` follows one cycle later. A capture that re-arms too early shows as a changed code or position after the second event. A wrong clear rule shows as a flag that survives or vanishes on the cycle after `stat_rd` or `rx_release`.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int NFLAG    = 11;
  localparam int NAUX     = 4;
  localparam int ALC_W    = 5;
  localparam int FIELD_W  = 8;
  localparam int B_RX     = 0;
  localparam int B_TX1    = 1;
  localparam int B_CHG    = 2;
  localparam int B_OVR    = 3;
  localparam int B_WAKE   = 4;
  localparam int B_BERR   = 5;
  localparam int B_ARB    = 6;
  localparam int B_AUX0   = 7;
  localparam int ECC_LSB  = 16;
  localparam int ALC_LSB  = 24;
  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/can_irq_capture.sv
module can_irq_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt,
  input  logic [W-1:0] val,
  input  logic         rd,
  output logic         flag,
  output logic [W-1:0] hold
);
  logic         flag_q, flag_n, accept;
  logic [W-1:0] hold_q, hold_n;

  always_comb begin
    accept = evt & (~flag_q | rd);
    flag_n = accept | (flag_q & ~rd);
    hold_n = accept ? val : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      hold_q <= '0;
    end else begin
      flag_q <= flag_n;
      if (accept) hold_q <= hold_n;
    end
  end

  assign flag = flag_q;
  assign hold = hold_q;
endmodule

// File: rtl/can_irq_flags.sv
module can_irq_flags #(
  parameter int NP = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_full,
  input  logic          rx_release,
  input  logic          wake_set,
  input  logic [NP-1:0] pulse_evt,
  input  logic          rd,
  output logic          rx_flag,
  output logic          wake_flag,
  output logic [NP-1:0] pulse_flag
);
  logic          rx_q, rx_n, wake_q, wake_n;
  logic [NP-1:0] pf_q, pf_n;

  always_comb begin
    rx_n   = rx_release ? 1'b0 : rx_full;
    wake_n = wake_set | (wake_q & ~rd);
    pf_n   = pulse_evt | (pf_q & ~{NP{rd}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q   <= 1'b0;
      wake_q <= 1'b0;
      pf_q   <= '0;
    end else begin
      rx_q   <= rx_n;
      wake_q <= wake_n;
      pf_q   <= pf_n;
    end
  end

  assign rx_flag    = rx_q;
  assign wake_flag  = wake_q;
  assign pulse_flag = pf_q;
endmodule

// File: rtl/can_irq_unit.sv
module can_irq_unit
  import can_irq_pkg::*;
#(
  parameter int ECC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_full,
  input  logic              rx_release,
  input  logic              tx1_done,
  input  logic              err_change,
  input  logic              overrun,
  input  logic [NAUX-1:0]   aux_evt,
  input  logic              wake_evt,
  input  logic              sleep_req,
  input  logic              bus_active,
  input  logic              berr_evt,
  input  logic [ECC_W-1:0]  berr_code,
  input  logic              arb_lost_evt,
  input  logic [ALC_W-1:0]  arb_pos,
  input  logic              en_wr,
  input  logic [NFLAG-1:0]  en_wdata,
  input  logic              stat_rd,
  output logic [NFLAG-1:0]  en_rdata,
  output logic [31:0]       stat_word,
  output logic              irq
);
  localparam int NP = 3 + NAUX;

  flag_vec_t        en_q, en_n, flags;
  logic             irq_q, irq_n, pending, wake_set;
  logic [NP-1:0]    pulse_evt, pulse_flag;
  logic             rx_flag, wake_flag, berr_flag, arb_flag;
  logic [ECC_W-1:0] ecc_hold;
  logic [ALC_W-1:0] alc_hold;

  assign pulse_evt = {aux_evt, overrun, err_change, tx1_done};
  assign pending   = |(flags & en_q);
  assign wake_set  = wake_evt | (sleep_req & (bus_active | pending));

  can_irq_flags #(.NP(NP)) u_flags (
    .clk(clk), .rst_n(rst_n), .rx_full(rx_full), .rx_release(rx_release),
    .wake_set(wake_set), .pulse_evt(pulse_evt), .rd(stat_rd),
    .rx_flag(rx_flag), .wake_flag(wake_flag), .pulse_flag(pulse_flag)
  );

  can_irq_capture #(.W(ECC_W)) u_berr (
    .clk(clk), .rst_n(rst_n), .evt(berr_evt), .val(berr_code),
    .rd(stat_rd), .flag(berr_flag), .hold(ecc_hold)
  );

  can_irq_capture #(.W(ALC_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .evt(arb_lost_evt), .val(arb_pos),
    .rd(stat_rd), .flag(arb_flag), .hold(alc_hold)
  );

  always_comb begin
    flags                         = '0;
    flags[B_RX]                   = rx_flag;
    flags[B_TX1]                  = pulse_flag[0];
    flags[B_CHG]                  = pulse_flag[1];
    flags[B_OVR]                  = pulse_flag[2];
    flags[B_WAKE]                 = wake_flag;
    flags[B_BERR]                 = berr_flag;
    flags[B_ARB]                  = arb_flag;
    flags[B_AUX0 +: NAUX]         = pulse_flag[3 +: NAUX];
  end

  always_comb begin
    en_n  = en_wr ? en_wdata : en_q;
    irq_n = pending;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      if (en_wr) en_q <= en_n;
      irq_q <= irq_n;
    end
  end

  always_comb begin
    stat_word                          = '0;
    stat_word[NFLAG-1:0]               = flags;
    stat_word[ECC_LSB +: ECC_W]        = ecc_hold;
    stat_word[ALC_LSB +: ALC_W]        = alc_hold;
  end

  assign en_rdata = en_q;
  assign irq      = irq_q;
endmodule

// File: rtl/can_irq_unit_chk.sv
module can_irq_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_full,
  input logic        rx_release,
  input logic        tx1_done,
  input logic        stat_rd,
  input logic [10:0] en_rdata,
  input logic [31:0] stat_word,
  input logic        irq
);
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|(stat_word[10:0] & en_rdata))); // R2
  AST_RX_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rx_release) |=> stat_word[0]); // R3
  AST_RX_RELEASE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_release |=> !stat_word[0]); // R4
  AST_TX_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    tx1_done |=> stat_word[1]); // R5
  AST_TX_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !tx1_done) |=> !stat_word[1]); // R5
  AST_ECC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word[5] && !stat_rd) |=> $stable(stat_word[23:16])); // R7
  AST_ALC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word[6] && !stat_rd) |=> $stable(stat_word[31:24])); // R8
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[15:11] == 5'd0); // R9
endmodule

bind can_irq_unit can_irq_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_full(rx_full), .rx_release(rx_release),
  .tx1_done(tx1_done), .stat_rd(stat_rd), .en_rdata(en_rdata),
  .stat_word(stat_word), .irq(irq)
);

// File: tb/can_irq_unit_tb.sv
module can_irq_unit_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic rx_full, rx_release, tx1_done, err_change, overrun;
  logic [3:0] aux_evt;
  logic wake_evt, sleep_req, bus_active, berr_evt, arb_lost_evt;
  logic [7:0] berr_code;
  logic [4:0] arb_pos;
  logic en_wr, stat_rd;
  logic [10:0] en_wdata, en_rdata;
  logic [31:0] stat_word;
  logic irq;

  int checks = 0, errors = 0;
  logic [10:0] m_flags, m_en;
  logic [7:0]  m_ecc;
  logic [4:0]  m_alc;
  logic        m_irq;

  always #5 clk = ~clk;

  can_irq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .rx_full(rx_full), .rx_release(rx_release),
    .tx1_done(tx1_done), .err_change(err_change), .overrun(overrun),
    .aux_evt(aux_evt), .wake_evt(wake_evt), .sleep_req(sleep_req),
    .bus_active(bus_active), .berr_evt(berr_evt), .berr_code(berr_code),
    .arb_lost_evt(arb_lost_evt), .arb_pos(arb_pos), .en_wr(en_wr),
    .en_wdata(en_wdata), .stat_rd(stat_rd), .en_rdata(en_rdata),
    .stat_word(stat_word), .irq(irq)
  );

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    rx_release = 0; tx1_done = 0; err_change = 0; overrun = 0; aux_evt = 0;
    wake_evt = 0; sleep_req = 0; bus_active = 0; berr_evt = 0; arb_lost_evt = 0;
    en_wr = 0; stat_rd = 0;
  endtask

  function automatic logic [31:0] exp_word();
    return {3'b0, m_alc, m_ecc, 5'b0, m_flags};
  endfunction

  // one clock: advance reference model from current inputs, then compare all ports
  task automatic cycle();
    logic [10:0] f, e;
    logic [7:0]  c;
    logic [4:0]  a;
    logic pend, wset, acc;
    pend = |(m_flags & m_en);
    f = m_flags; e = m_en; c = m_ecc; a = m_alc;
    f[0] = rx_release ? 1'b0 : rx_full;
    f[1] = tx1_done   | (m_flags[1] & ~stat_rd);
    f[2] = err_change | (m_flags[2] & ~stat_rd);
    f[3] = overrun    | (m_flags[3] & ~stat_rd);
    wset = wake_evt | (sleep_req & (bus_active | pend));
    f[4] = wset | (m_flags[4] & ~stat_rd);
    acc  = berr_evt & (~m_flags[5] | stat_rd);
    f[5] = acc | (m_flags[5] & ~stat_rd);
    if (acc) c = berr_code;
    acc  = arb_lost_evt & (~m_flags[6] | stat_rd);
    f[6] = acc | (m_flags[6] & ~stat_rd);
    if (acc) a = arb_pos;
    for (int i = 0; i < 4; i++) f[7+i] = aux_evt[i] | (m_flags[7+i] & ~stat_rd);
    if (en_wr) e = en_wdata;
    @(posedge clk); #2;
    m_flags = f; m_en = e; m_ecc = c; m_alc = a; m_irq = pend;
    chk(stat_word, exp_word(), "R5 R9 status word");
    chk({21'b0, en_rdata}, {21'b0, m_en}, "R9 enable readback");
    chk({31'b0, irq}, {31'b0, m_irq}, "R2 irq");
    idle();
  endtask

  initial begin
    idle(); rx_full = 0; berr_code = 0; arb_pos = 0; en_wdata = 0;
    m_flags = 0; m_en = 0; m_ecc = 0; m_alc = 0; m_irq = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(stat_word, 32'h0, "R1 reset status");
    chk({21'b0, en_rdata}, 32'h0, "R1 reset enable");
    chk({31'b0, irq}, 32'h0, "R1 reset irq");
    @(negedge clk);

    // R5 / R9: pulse sources and their bit positions
    tx1_done = 1; cycle(); chk(stat_word, 32'h2, "R5 tx1 bit1");
    err_change = 1; overrun = 1; cycle(); chk(stat_word[3:0], 32'hE, "R5 chg/ovr bits");
    aux_evt = 4'b1001; cycle(); chk(stat_word[10:7], 32'h9, "R5 aux bits 7..10");
    stat_rd = 1; overrun = 1; cycle(); chk(stat_word, 32'h8, "R5 read clears, same-cycle event wins");
    stat_rd = 1; cycle(); chk(stat_word, 32'h0, "R5 read clears");

    // R2: masked flag gives no irq, enabling it does
    tx1_done = 1; cycle(); cycle(); chk({31'b0, irq}, 32'h0, "R2 masked no irq");
    en_wr = 1; en_wdata = 11'h002; cycle(); cycle(); chk({31'b0, irq}, 32'h1, "R2 enabled irq");
    stat_rd = 1; cycle(); cycle(); chk({31'b0, irq}, 32'h0, "R2 irq drops after clear");

    // R3 / R4: receive level
    rx_full = 1; cycle(); chk({31'b0, stat_word[0]}, 32'h1, "R3 rx flag set");
    stat_rd = 1; cycle(); chk({31'b0, stat_word[0]}, 32'h1, "R3 read keeps rx");
    rx_release = 1; cycle(); chk({31'b0, stat_word[0]}, 32'h0, "R4 release clears");
    cycle(); chk({31'b0, stat_word[0]}, 32'h1, "R4 sets again with message waiting");
    rx_release = 1; rx_full = 0; cycle(); cycle();
    chk({31'b0, stat_word[0]}, 32'h0, "R4 stays clear when empty");

    // R6: wake-up
    en_wr = 1; en_wdata = 11'h000; cycle();
    sleep_req = 1; cycle(); chk({31'b0, stat_word[4]}, 32'h0, "R6 idle sleep no wake");
    sleep_req = 1; bus_active = 1; cycle(); chk({31'b0, stat_word[4]}, 32'h1, "R6 sleep while busy");
    cycle(); chk({31'b0, irq}, 32'h0, "R6 masked wake no irq");
    stat_rd = 1; cycle();
    en_wr = 1; en_wdata = 11'h008; overrun = 1; cycle(); cycle();
    sleep_req = 1; cycle(); chk({31'b0, stat_word[4]}, 32'h1, "R6 sleep while pending");
    wake_evt = 1; stat_rd = 1; cycle(); chk({31'b0, stat_word[4]}, 32'h1, "R6 wake event");

    // R7 / R8 / R10: captures
    stat_rd = 1; cycle();
    berr_evt = 1; berr_code = 8'h5A; cycle(); chk(stat_word[23:16], 32'h5A, "R7 code captured");
    berr_evt = 1; berr_code = 8'h33; cycle(); chk(stat_word[23:16], 32'h5A, "R7 code frozen");
    arb_lost_evt = 1; arb_pos = 5'd13; cycle(); chk(stat_word[31:24], 32'd13, "R8 position captured");
    arb_lost_evt = 1; arb_pos = 5'd31; cycle(); chk(stat_word[31:24], 32'd13, "R8 position frozen");
    stat_rd = 1; cycle(); chk(stat_word[6:5], 32'h0, "R7 R8 read clears flags");
    berr_evt = 1; berr_code = 8'h33; cycle(); chk(stat_word[23:16], 32'h33, "R7 rearmed");
    arb_lost_evt = 1; arb_pos = 5'd11; cycle();
    arb_lost_evt = 1; arb_pos = 5'd31; stat_rd = 1; cycle();
    chk(stat_word[31:24], 32'd31, "R10 arb capture with read");
    chk({31'b0, stat_word[6]}, 32'h1, "R10 arb flag kept");
    berr_evt = 1; berr_code = 8'hC3; stat_rd = 1; cycle();
    chk(stat_word[23:16], 32'hC3, "R10 berr capture with read");

    // random traffic against the model
    void'($urandom(32'd7));
    for (int n = 0; n < 3000; n++) begin
      rx_full      = ($urandom % 4) != 0;
      rx_release   = ($urandom % 8) == 0;
      tx1_done     = ($urandom % 10) == 0;
      err_change   = ($urandom % 12) == 0;
      overrun      = ($urandom % 12) == 0;
      aux_evt      = 4'($urandom) & 4'($urandom) & 4'($urandom);
      wake_evt     = ($urandom % 20) == 0;
      sleep_req    = ($urandom % 10) == 0;
      bus_active   = ($urandom % 2) == 0;
      berr_evt     = ($urandom % 8) == 0;
      berr_code    = 8'($urandom);
      arb_lost_evt = ($urandom % 8) == 0;
      arb_pos      = 5'($urandom);
      en_wr        = ($urandom % 16) == 0;
      en_wdata     = 11'($urandom);
      stat_rd      = ($urandom % 5) == 0;
      cycle();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule